// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the array address for each beat of a four-beat burst in a synchronous burst SRAM. When the cycle decoder pulses a load strobe (from either address-status input), the external word address is captured. The upper address bits stay as captured for the whole burst. The two low bits follow a burst sequence that starts from the captured low bits.

A static order input chooses the sequence. Linear order counts the low bits upward modulo four. Interleaved order XORs the start value with a beat count that runs 0, 1, 2, 3. An active-low step input moves to the next beat on a clock edge, and holding it high inserts a wait state. After the fourth beat the sequence wraps back to the start. A new load abandons any burst in progress.

The decoder decides when to load. The memory array and the data path are outside this block. The output is driven from registers only, with one mux level after them, so it is valid in the cycle that follows the edge that loaded or stepped it.

Top module: `burst_addr_gen`

## Requirements
- R1: The bits of `addr_o` above the two burst bits equal the upper bits of `addr_i` captured at the most recent load. Changes on `addr_i` have no effect while `load_i` is low.
- R2: With `order_i` = 0 (linear), each step adds one modulo 4 to the low two bits. A start of 01 gives 01, 10, 11, 00.
- R3: With `order_i` = 1 (interleaved), the low two bits on beat k (k = 0..3) are the start value XOR k. A start of 01 gives 01, 00, 11, 10, and a start of 10 gives 10, 11, 00, 01.
- R4: `step_n_i` low at a rising edge with `load_i` low advances `addr_o` to the next beat in the selected order.
- R5: `step_n_i` high at a rising edge with `load_i` low leaves `addr_o` unchanged. This includes the first edge after a load.
- R6: A step taken from the fourth beat returns the low bits to the start value.
- R7: `load_i` high at a rising edge makes `addr_o` equal that edge's `addr_i` in the following cycle, and restarts the beat count even mid-burst.
- R8: When `load_i` and `step_n_i` low occur at the same edge, the load wins: `addr_o` becomes `addr_i` with no step applied.
- R9: `rst` high at a rising edge (synchronous) makes `addr_o` all zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Capture `addr_i` and restart the burst |
| step_n_i | input | 1 | Active-low burst advance; high holds the beat |
| order_i | input | 1 | 0 = linear, 1 = interleaved; held static |
| addr_i | input | ADDR_W | External word address |
| addr_o | output | ADDR_W | Current array address |

## Verification
The internal state is the captured upper bits, the start value and the beat count. A wrong beat count shows up in the low bits of `addr_o` in the cycle after the faulty edge. In linear mode it appears as a skipped or repeated value. In interleaved mode it appears as a wrong XOR pattern, which is visible only after the first step from the start. Upper bits that are lost or wrongly recaptured show on the port at once, so the bench drives changing `addr_i` values between loads. Because beat-count faults are only visible once the sequence moves, the bench walks every burst through its wrap point and compares against the model on each clock.

// File: rtl/burst_pkg.sv
package burst_pkg;
    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
    parameter int BURST_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load_i,
    input  logic                  step_n_i,
    output logic [BURST_BITS-1:0] beat_o
);
    localparam logic [BURST_BITS-1:0] BEAT_LAST = '1;

    typedef struct packed {
        logic [BURST_BITS-1:0] beat;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.beat = '0;
        end else if (!step_n_i) begin
            st_d.beat = st_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign beat_o = st_q.beat;

    // R6: stepping from the last beat wraps to beat zero
    assert_beat_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !step_n_i && st_q.beat == BEAT_LAST) |=> (st_q.beat == '0));

    // R7: a load restarts the beat count
    assert_load_clears_R7: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (st_q.beat == '0));
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
    parameter int ADDR_W     = 18,
    parameter int BURST_BITS = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load_i,
    input  logic [ADDR_W-1:0]          addr_i,
    output logic [ADDR_W-BURST_BITS-1:0] base_o,
    output logic [BURST_BITS-1:0]      start_o
);
    localparam int BASE_W = ADDR_W - BURST_BITS;

    typedef struct packed {
        logic [BASE_W-1:0]     base;
        logic [BURST_BITS-1:0] start;
    } areg_state_t;

    areg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.base  = addr_i[ADDR_W-1:BURST_BITS];
            st_d.start = addr_i[BURST_BITS-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign base_o  = st_q.base;
    assign start_o = st_q.start;
endmodule

// File: rtl/burst_seq_map.sv
module burst_seq_map
    import burst_pkg::*;
#(
    parameter int BURST_BITS = 2
) (
    input  order_e                order_i,
    input  logic [BURST_BITS-1:0] start_i,
    input  logic [BURST_BITS-1:0] beat_i,
    output logic [BURST_BITS-1:0] low_o
);
    logic [BURST_BITS:0]   sum_w;
    logic [BURST_BITS-1:0] lin_w;
    logic [BURST_BITS-1:0] ilv_w;

    assign sum_w = {1'b0, start_i} + {1'b0, beat_i};
    assign lin_w = sum_w[BURST_BITS-1:0];

    for (genvar b = 0; b < BURST_BITS; b++) begin : g_ilv
        assign ilv_w[b] = start_i[b] ^ beat_i[b];
    end

    always_comb begin
        low_o = (order_i == ORDER_INTERLEAVE) ? ilv_w : lin_w;
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int BURST_BITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              step_n_i,
    input  logic              order_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int BASE_W = ADDR_W - BURST_BITS;

    logic [BASE_W-1:0]     base_w;
    logic [BURST_BITS-1:0] start_w;
    logic [BURST_BITS-1:0] beat_w;
    logic [BURST_BITS-1:0] low_w;
    order_e                order_w;

    assign order_w = order_e'(order_i);

    burst_addr_reg #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_areg (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load_i),
        .addr_i  (addr_i),
        .base_o  (base_w),
        .start_o (start_w)
    );

    burst_beat_ctr #(.BURST_BITS(BURST_BITS)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load_i),
        .step_n_i (step_n_i),
        .beat_o   (beat_w)
    );

    burst_seq_map #(.BURST_BITS(BURST_BITS)) u_map (
        .order_i (order_w),
        .start_i (start_w),
        .beat_i  (beat_w),
        .low_o   (low_w)
    );

    assign addr_o = {base_w, low_w};

    // R1: upper bits never move without a load
    assert_upper_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(addr_o[ADDR_W-1:BURST_BITS]));

    // R5: a wait state keeps the whole address
    assert_wait_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!load_i && step_n_i && $stable(order_i)) |=> $stable(addr_o));

    // R2: linear step adds one to the low bits
    assert_linear_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !step_n_i && !order_i) |=>
        (order_i || addr_o[BURST_BITS-1:0] == $past(addr_o[BURST_BITS-1:0]) + 1'b1));

    // R7 / R8: a load presents the external address next cycle, step or not
    assert_load_addr_R7: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (addr_o == $past(addr_i)));
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 18;
    localparam int BB         = 2;
    localparam int NBEAT      = 1 << BB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_i = 1'b0;
    logic          step_n_i = 1'b1;
    logic          order_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] addr_o;

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    string tag = "R9";
    bit    done = 1'b0;

    int ref_base = 0;
    int ref_start = 0;
    int ref_beat = 0;

    burst_addr_gen #(.ADDR_W(AW), .BURST_BITS(BB)) uut (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load_i),
        .step_n_i (step_n_i),
        .order_i  (order_i),
        .addr_i   (addr_i),
        .addr_o   (addr_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            ref_base <= 0; ref_start <= 0; ref_beat <= 0;
        end else if (load_i) begin
            ref_base  <= int'(addr_i) / NBEAT;
            ref_start <= int'(addr_i) % NBEAT;
            ref_beat  <= 0;
        end else if (!step_n_i) begin
            ref_beat <= (ref_beat + 1) % NBEAT;
        end
    end

    function automatic int expect_addr();
        int lo;
        if (order_i) lo = ref_start ^ ref_beat;
        else         lo = (ref_start + ref_beat) % NBEAT;
        return ref_base * NBEAT + lo;
    endfunction

    always @(negedge clk) begin
        if (!done) begin
            int e;
            e = expect_addr();
            total++;
            if (int'(addr_o) != e) begin
                bad++;
                $display("FAIL %s: addr_o=%h expected=%h at cycle %0d", tag, addr_o, e, cycles);
            end
        end
    end

    task automatic cyc(input bit ld, input bit sn, input logic [AW-1:0] a);
        @(posedge clk); #1;
        load_i = ld; step_n_i = sn; addr_i = a;
    endtask

    initial begin
        // R9: reset state
        tag = "R9";
        repeat (3) cyc(0, 1, '0);
        @(posedge clk); #1; rst = 1'b0;

        // R5: hold after load; R2/R4: linear stepping; R6: wrap
        tag = "R2";
        order_i = 1'b0;
        cyc(1, 1, 18'h2A5C1);
        tag = "R5"; cyc(0, 1, 18'h3FFFF);
        tag = "R4"; cyc(0, 0, 18'h00000);
        tag = "R2"; cyc(0, 0, 18'h12345);
        tag = "R5"; cyc(0, 1, 18'h12345); cyc(0, 1, 18'h12345);
        tag = "R2"; cyc(0, 0, 18'h0);
        tag = "R6"; cyc(0, 0, 18'h0); cyc(0, 0, 18'h0); cyc(0, 1, 18'h0);

        // R3: interleaved with every start value
        order_i = 1'b1;
        for (int s = 0; s < NBEAT; s++) begin
            tag = "R3";
            cyc(1, 1, 18'h1F000 | 18'(s));
            for (int k = 0; k < NBEAT + 1; k++) cyc(0, 0, 18'h0ABCD);
            cyc(0, 1, 18'h0);
        end

        // R1: address changes without a load are ignored
        tag = "R1";
        cyc(1, 1, 18'h15556);
        for (int k = 0; k < 6; k++) cyc(0, k % 2, 18'(k * 18'h0A5A7));

        // R7: load mid burst restarts
        order_i = 1'b0;
        tag = "R7";
        cyc(1, 1, 18'h00003);
        cyc(0, 0, 18'h0); cyc(0, 0, 18'h0);
        cyc(1, 1, 18'h3C002);
        cyc(0, 0, 18'h0); cyc(0, 1, 18'h0);

        // R8: load and step on same edge
        tag = "R8";
        cyc(1, 0, 18'h20001);
        cyc(0, 1, 18'h0);
        cyc(1, 0, 18'h10003);
        cyc(0, 0, 18'h0); cyc(0, 1, 18'h0);

        // R9: reset in the middle of a burst
        tag = "R9";
        cyc(0, 0, 18'h0);
        @(posedge clk); #1; rst = 1'b1; step_n_i = 1'b1;
        cyc(0, 1, 18'h0);
        @(posedge clk); #1; rst = 1'b0;
        cyc(0, 1, 18'h0);

        @(negedge clk); #1;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule